// File: doc/BRIEF.md
# Programmable Test Pattern Generator

This block produces a serial test bit stream, one bit for every clock cycle in which its bit-enable input is high. It has two sources. The first is a pseudorandom sequence from a two-tap Fibonacci shift register whose length, tap position and start value are set at run time. The second is a user word of programmable length that repeats. The stream feeds a line or loopback path under test, and a matching checker elsewhere counts the bit errors.

An error injector inverts single outgoing bits. A software command can request an error. A rising edge on an external request pin can request an error. Errors can also be requested at a fixed decade rate of one per 10^k bits. An injected error changes only the emitted bit, so the pattern itself keeps running unchanged. An output pulse marks each bit that was inverted. The configuration is latched when the restart strobe is pulsed. The strobe also loads the start value and restarts the pattern.

Top module: `patgen_top`

## Requirements
- R1: While reset is low and after it is released, `data_o` and `err_o` are 0 until the first enabled bit.
- R2: Pseudorandom mode (`cfg_mode_i`=0) uses an n-bit state s. The emitted bit is s[n-1]. On each enabled bit the state shifts left by one, and bit 0 takes s[n-1] XOR s[y-1], where n is the latched length and y the latched tap. A tap outside 1..n-1 drops the second term.
- R3: A restart pulse latches mode, length, tap and the seed/word input masked to n bits. A length of 0 is treated as 1 and a length above 32 as 32. In pseudorandom mode a masked seed of zero loads all ones. The first bit after a restart is bit n-1 of the loaded value.
- R4: Word mode (`cfg_mode_i`=1) emits the latched word MSB first, starting at bit n-1 and ending at bit 0, then wraps to bit n-1.
- R5: Each result appears on `data_o`/`err_o` one cycle after the enabled edge. When `bit_en_i` is low, or `restart_i` is high, the pattern does not advance, `data_o` holds and `err_o` is 0 in the next cycle.
- R6: A pulse on `inj_single_i` inverts the next enabled bit, which may be in the same cycle, and `err_o` is 1 with that bit.
- R7: A 0-to-1 transition of `inj_pin_i`, sampled on the clock, requests one error in the same way. A pin held high requests nothing further.
- R8: With `inj_rate_en_i` high, one error is injected every 10^k enabled bits. The first falls on the 10^k-th enabled bit after enabling or restart. k is `inj_rate_i`, where 0 acts as 1 and values above 7 act as 7.
- R9: A change of `inj_rate_i` while the rate mode runs takes effect only after the next rate injection.
- R10: An injection never changes the pattern sequence. Only the emitted bit is inverted.
- R11: Requests that wait for an enabled bit merge into one error. A restart discards waiting requests and any request made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_mode_i | input | 1 | 0 pseudorandom, 1 repeating word |
| cfg_len_i | input | 6 | Pattern length n |
| cfg_tap_i | input | 6 | Feedback tap y |
| cfg_seed_i | input | 32 | Seed (pseudorandom) or word (repeating) |
| restart_i | input | 1 | Latch configuration and restart the pattern |
| bit_en_i | input | 1 | Emit and advance one bit this cycle |
| inj_single_i | input | 1 | Software single-error request |
| inj_pin_i | input | 1 | External error request pin, rising edge active |
| inj_rate_en_i | input | 1 | Enable decade-rate injection |
| inj_rate_i | input | 3 | Decade exponent k |
| data_o | output | 1 | Serial test bit |
| err_o | output | 1 | High with each inverted bit |

## Verification
Every result, both the emitted bit and the error mark, is registered once. A stimulus applied before the clock edge is seen at the outputs after that edge. Restart, request and enable effects therefore all show one cycle later. The bench drives inputs after a falling edge, advances its queue-based model at the following rising edge, and compares both outputs at the next falling edge. A request made while the enable is low shows up only in the cycle after the next enabled edge. Rate injections are due exactly 10^k enabled edges after the reload, and the model counts only enabled edges.

// File: rtl/patgen_pkg.sv
package patgen_pkg;

    typedef enum logic {
        PG_PRBS = 1'b0,
        PG_WORD = 1'b1
    } pg_mode_e;

    typedef struct packed {
        logic data;
        logic err;
    } pg_out_t;

endpackage

// File: rtl/patgen_seq.sv
module patgen_seq
    import patgen_pkg::*;
#(
    parameter int MAX_LEN = 32,
    localparam int LEN_W = $clog2(MAX_LEN + 1),
    localparam int IDX_W = $clog2(MAX_LEN)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               restart_i,
    input  logic               adv_i,
    input  logic               cfg_mode_i,
    input  logic [LEN_W-1:0]   cfg_len_i,
    input  logic [LEN_W-1:0]   cfg_tap_i,
    input  logic [MAX_LEN-1:0] cfg_seed_i,
    output logic               bit_o,
    output logic               mode_o,
    output logic [LEN_W-1:0]   len_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [MAX_LEN-1:0] state_o
);

    typedef struct packed {
        pg_mode_e           mode;
        logic [LEN_W-1:0]   len;
        logic [LEN_W-1:0]   tap;
        logic [IDX_W-1:0]   idx;
        logic [MAX_LEN-1:0] state;
    } seq_st_t;

    seq_st_t seq_d, seq_q;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
        if (l == '0)
            return LEN_W'(1);
        else if (l > LEN_W'(MAX_LEN))
            return LEN_W'(MAX_LEN);
        else
            return l;
    endfunction

    function automatic logic [MAX_LEN-1:0] len_mask(input logic [LEN_W-1:0] l);
        logic [MAX_LEN-1:0] m;
        for (int i = 0; i < MAX_LEN; i++)
            m[i] = (LEN_W'(i) < l);
        return m;
    endfunction

    logic [LEN_W-1:0]   new_len;
    logic [MAX_LEN-1:0] new_mask;
    logic [MAX_LEN-1:0] cur_mask;
    logic [MAX_LEN-1:0] loaded;
    logic [IDX_W-1:0]   top_bit;
    logic [IDX_W-1:0]   tap_bit;
    logic               tap_ok;
    logic               fb;

    always_comb begin
        seq_d    = seq_q;
        new_len  = clamp_len(cfg_len_i);
        new_mask = len_mask(new_len);
        cur_mask = len_mask(seq_q.len);
        top_bit  = IDX_W'(seq_q.len - LEN_W'(1));
        tap_bit  = IDX_W'(seq_q.tap - LEN_W'(1));
        tap_ok   = (seq_q.tap != '0) && (seq_q.tap < seq_q.len);
        fb       = seq_q.state[top_bit] ^ (tap_ok & seq_q.state[tap_bit]);
        loaded   = cfg_seed_i & new_mask;

        if (restart_i) begin
            seq_d.mode = pg_mode_e'(cfg_mode_i);
            seq_d.len  = new_len;
            seq_d.tap  = cfg_tap_i;
            seq_d.idx  = IDX_W'(new_len - LEN_W'(1));
            if (pg_mode_e'(cfg_mode_i) == PG_PRBS && loaded == '0)
                seq_d.state = new_mask;
            else
                seq_d.state = loaded;
        end else if (adv_i) begin
            if (seq_q.mode == PG_WORD) begin
                if (seq_q.idx == '0)
                    seq_d.idx = top_bit;
                else
                    seq_d.idx = seq_q.idx - IDX_W'(1);
            end else begin
                seq_d.state = ({seq_q.state[MAX_LEN-2:0], fb}) & cur_mask;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q.mode  <= PG_PRBS;
            seq_q.len   <= LEN_W'(MAX_LEN);
            seq_q.tap   <= LEN_W'(MAX_LEN - 1);
            seq_q.idx   <= '0;
            seq_q.state <= '1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign bit_o   = (seq_q.mode == PG_WORD) ? seq_q.state[seq_q.idx]
                                             : seq_q.state[top_bit];
    assign mode_o  = seq_q.mode;
    assign len_o   = seq_q.len;
    assign idx_o   = seq_q.idx;
    assign state_o = seq_q.state;

endmodule

// File: rtl/patgen_rate.sv
module patgen_rate #(
    parameter int SEL_W   = 3,
    parameter int MAX_DEC = 7,
    parameter int CNT_W   = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic             en_i,
    input  logic             adv_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             hit_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } rate_st_t;

    rate_st_t rate_d, rate_q;

    function automatic logic [CNT_W-1:0] period_m1(input logic [SEL_W-1:0] s);
        int k;
        int p;
        k = int'(s);
        if (k < 1)
            k = 1;
        if (k > MAX_DEC)
            k = MAX_DEC;
        p = 1;
        for (int i = 0; i < MAX_DEC; i++)
            if (i < k)
                p = p * 10;
        return CNT_W'(p - 1);
    endfunction

    logic [CNT_W-1:0] reload;
    logic             hit;

    always_comb begin
        rate_d = rate_q;
        reload = period_m1(sel_i);
        hit    = en_i && adv_i && !restart_i && (rate_q.cnt == '0);
        if (restart_i || !en_i)
            rate_d.cnt = reload;
        else if (adv_i)
            rate_d.cnt = hit ? reload : rate_q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            rate_q.cnt <= period_m1(SEL_W'(1));
        else
            rate_q <= rate_d;
    end

    assign hit_o = hit;

endmodule

// File: rtl/patgen_inj.sv
module patgen_inj (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  logic adv_i,
    input  logic single_i,
    input  logic pin_i,
    input  logic rate_hit_i,
    output logic inject_o
);

    typedef struct packed {
        logic pin;
        logic pend;
    } inj_st_t;

    inj_st_t inj_d, inj_q;
    logic    req;
    logic    inject;

    always_comb begin
        inj_d     = inj_q;
        req       = single_i | (pin_i & ~inj_q.pin);
        inject    = adv_i && !restart_i && (inj_q.pend || req || rate_hit_i);
        inj_d.pin = pin_i;
        if (restart_i)
            inj_d.pend = 1'b0;
        else if (adv_i)
            inj_d.pend = 1'b0;
        else
            inj_d.pend = inj_q.pend | req;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            inj_q.pin  <= 1'b0;
            inj_q.pend <= 1'b0;
        end else begin
            inj_q <= inj_d;
        end
    end

    assign inject_o = inject;

endmodule

// File: rtl/patgen_top.sv
module patgen_top
    import patgen_pkg::*;
#(
    parameter int MAX_LEN = 32,
    parameter int SEL_W   = 3,
    parameter int MAX_DEC = 7,
    parameter int CNT_W   = 24,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int IDX_W  = $clog2(MAX_LEN)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cfg_mode_i,
    input  logic [LEN_W-1:0]   cfg_len_i,
    input  logic [LEN_W-1:0]   cfg_tap_i,
    input  logic [MAX_LEN-1:0] cfg_seed_i,
    input  logic               restart_i,
    input  logic               bit_en_i,
    input  logic               inj_single_i,
    input  logic               inj_pin_i,
    input  logic               inj_rate_en_i,
    input  logic [SEL_W-1:0]   inj_rate_i,
    output logic               data_o,
    output logic               err_o
);

    logic               adv;
    logic               gen_bit;
    logic               rate_hit;
    logic               inject;
    logic               seq_mode;
    logic [LEN_W-1:0]   seq_len;
    logic [IDX_W-1:0]   seq_idx;
    logic [MAX_LEN-1:0] seq_state;

    pg_out_t out_d, out_q;

    assign adv = bit_en_i & ~restart_i;

    patgen_seq #(.MAX_LEN(MAX_LEN)) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .restart_i  (restart_i),
        .adv_i      (adv),
        .cfg_mode_i (cfg_mode_i),
        .cfg_len_i  (cfg_len_i),
        .cfg_tap_i  (cfg_tap_i),
        .cfg_seed_i (cfg_seed_i),
        .bit_o      (gen_bit),
        .mode_o     (seq_mode),
        .len_o      (seq_len),
        .idx_o      (seq_idx),
        .state_o    (seq_state)
    );

    patgen_rate #(.SEL_W(SEL_W), .MAX_DEC(MAX_DEC), .CNT_W(CNT_W)) u_rate (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart_i),
        .en_i      (inj_rate_en_i),
        .adv_i     (adv),
        .sel_i     (inj_rate_i),
        .hit_o     (rate_hit)
    );

    patgen_inj u_inj (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .restart_i  (restart_i),
        .adv_i      (adv),
        .single_i   (inj_single_i),
        .pin_i      (inj_pin_i),
        .rate_hit_i (rate_hit),
        .inject_o   (inject)
    );

    always_comb begin
        out_d     = out_q;
        out_d.err = inject;
        if (adv)
            out_d.data = gen_bit ^ inject;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q.data <= 1'b0;
            out_q.err  <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign data_o = out_q.data;
    assign err_o  = out_q.err;

endmodule

// File: rtl/patgen_chk.sv
module patgen_chk #(
    parameter int MAX_LEN = 32,
    parameter int LEN_W   = 6,
    parameter int IDX_W   = 5
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               restart_i,
    input logic               bit_en_i,
    input logic               inj_single_i,
    input logic               data_o,
    input logic               err_o,
    input logic               seq_mode,
    input logic [LEN_W-1:0]   seq_len,
    input logic [IDX_W-1:0]   seq_idx,
    input logic [MAX_LEN-1:0] seq_state
);

    // R5
    err_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bit_en_i |=> !err_o);

    // R5
    data_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bit_en_i |=> $stable(data_o));

    // R11
    restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (!err_o && $stable(data_o)));

    // R6
    single_inject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inj_single_i && bit_en_i && !restart_i) |=> err_o);

    // R3
    lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !seq_mode |-> (seq_state != '0));

    // R4
    word_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_mode |-> (LEN_W'(seq_idx) < seq_len));

endmodule

bind patgen_top patgen_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (restart_i),
    .bit_en_i     (bit_en_i),
    .inj_single_i (inj_single_i),
    .data_o       (data_o),
    .err_o        (err_o),
    .seq_mode     (seq_mode),
    .seq_len      (seq_len),
    .seq_idx      (seq_idx),
    .seq_state    (seq_state)
);

// File: tb/patgen_top_tb.sv
`timescale 1ns/1ps
module patgen_top_tb;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        cfg_mode_i = 1'b0;
    logic [5:0]  cfg_len_i = '0;
    logic [5:0]  cfg_tap_i = '0;
    logic [31:0] cfg_seed_i = '0;
    logic        restart_i = 1'b0;
    logic        bit_en_i = 1'b0;
    logic        inj_single_i = 1'b0;
    logic        inj_pin_i = 1'b0;
    logic        inj_rate_en_i = 1'b0;
    logic [2:0]  inj_rate_i = 3'd1;
    logic        data_o;
    logic        err_o;

    always #4 clk_i = ~clk_i;

    patgen_top u_dut (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .cfg_mode_i    (cfg_mode_i),
        .cfg_len_i     (cfg_len_i),
        .cfg_tap_i     (cfg_tap_i),
        .cfg_seed_i    (cfg_seed_i),
        .restart_i     (restart_i),
        .bit_en_i      (bit_en_i),
        .inj_single_i  (inj_single_i),
        .inj_pin_i     (inj_pin_i),
        .inj_rate_en_i (inj_rate_en_i),
        .inj_rate_i    (inj_rate_i),
        .data_o        (data_o),
        .err_o         (err_o)
    );

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";

    // behavioural model state
    bit    mq[$];
    bit    m_word;
    int    m_len;
    int    m_tap;
    bit    m_pend;
    bit    m_pin;
    int    m_left;
    bit    e_data;
    bit    e_err;
    int    err_seen;

    function automatic int dec_period(input int s);
        int k = s;
        int p = 1;
        if (k < 1) k = 1;
        if (k > 7) k = 7;
        repeat (k) p = p * 10;
        return p;
    endfunction

    task automatic check(input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic model_restart();
        int n = int'(cfg_len_i);
        logic [31:0] v;
        if (n < 1) n = 1;
        if (n > 32) n = 32;
        m_len  = n;
        m_tap  = int'(cfg_tap_i);
        m_word = cfg_mode_i;
        v = cfg_seed_i;
        mq.delete();
        for (int j = 0; j < n; j++) mq.push_back(v[n-1-j]);
        if (!m_word) begin
            bit any = 1'b0;
            foreach (mq[j]) any |= mq[j];
            if (!any) foreach (mq[j]) mq[j] = 1'b1;
        end
    endtask

    function automatic bit model_next();
        bit b = mq[0];
        bit nb;
        if (m_word) begin
            nb = b;
        end else begin
            nb = b;
            if (m_tap >= 1 && m_tap < m_len) nb = b ^ mq[m_len - m_tap];
        end
        void'(mq.pop_front());
        mq.push_back(nb);
        return b;
    endfunction

    task automatic tick();
        bit rise;
        bit req;
        bit hit;
        @(posedge clk_i);
        rise = inj_pin_i && !m_pin;
        req  = inj_single_i || rise;
        if (restart_i) begin
            model_restart();
            m_pend = 1'b0;
            m_left = dec_period(int'(inj_rate_i)) - 1;
            e_err  = 1'b0;
        end else begin
            hit = 1'b0;
            if (!inj_rate_en_i) begin
                m_left = dec_period(int'(inj_rate_i)) - 1;
            end else if (bit_en_i) begin
                if (m_left == 0) begin
                    hit = 1'b1;
                    m_left = dec_period(int'(inj_rate_i)) - 1;
                end else begin
                    m_left--;
                end
            end
            if (bit_en_i) begin
                bit b = model_next();
                bit inj = m_pend || req || hit;
                e_data = b ^ inj;
                e_err  = inj;
                m_pend = 1'b0;
            end else begin
                m_pend = m_pend || req;
                e_err  = 1'b0;
            end
        end
        m_pin = inj_pin_i;
        @(negedge clk_i);
        check("data_o", data_o, e_data);
        check("err_o", err_o, e_err);
        if (err_o) err_seen++;
    endtask

    task automatic restart(input bit mode, input int len, input int tap, input logic [31:0] seed);
        cfg_mode_i = mode;
        cfg_len_i  = 6'(len);
        cfg_tap_i  = 6'(tap);
        cfg_seed_i = seed;
        restart_i  = 1'b1;
        bit_en_i   = 1'b1;
        tick();
        restart_i  = 1'b0;
    endtask

    task automatic run(input int n, input bit en);
        bit_en_i = en;
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_pin = 0; m_pend = 0; e_data = 0; e_err = 0; m_left = 9; m_len = 32; m_tap = 31; m_word = 0;
        err_seen = 0;
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk_i);
        check("data_o in reset", data_o, 1'b0);
        check("err_o in reset", err_o, 1'b0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("data_o after reset", data_o, 1'b0);
        check("err_o after reset", err_o, 1'b0);

        // R2 R3: pseudorandom patterns
        cur_req = "R2";
        restart(1'b0, 7, 6, 32'h5A);
        run(200, 1'b1);
        restart(1'b0, 32, 22, 32'hDEADBEEF);
        run(150, 1'b1);
        restart(1'b0, 15, 14, 32'hFFFF_0001);
        run(80, 1'b1);
        restart(1'b0, 5, 0, 32'h13);      // tap out of range: rotation
        run(20, 1'b1);
        cur_req = "R3";
        restart(1'b0, 9, 5, 32'h0000_0E00); // masked to zero -> all ones
        run(40, 1'b1);
        restart(1'b0, 0, 0, 32'h0);         // length 0 acts as 1
        run(8, 1'b1);
        restart(1'b0, 45, 3, 32'h8000_0001); // length above 32 acts as 32
        run(40, 1'b1);

        // R4: repeating word
        cur_req = "R4";
        restart(1'b1, 12, 0, 32'h0000_0A5C);
        run(60, 1'b1);
        restart(1'b1, 1, 0, 32'h1);
        run(5, 1'b1);
        restart(1'b1, 32, 0, 32'h8001_F00D);
        run(70, 1'b1);
        restart(1'b1, 3, 0, 32'h0);
        run(7, 1'b1);

        // R5: enable gaps
        cur_req = "R5";
        restart(1'b0, 11, 9, 32'h2F3);
        for (int i = 0; i < 300; i++) begin
            bit_en_i = 1'($urandom_range(0, 2) != 0);
            tick();
        end
        bit_en_i = 1'b1;

        // R6 R10: single command, pattern keeps running
        cur_req = "R6";
        restart(1'b0, 7, 6, 32'h41);
        run(5, 1'b1);
        err_seen = 0;
        inj_single_i = 1'b1; tick(); inj_single_i = 1'b0;
        run(10, 1'b1);
        check("one error from command", 1'(err_seen == 1), 1'b1);
        bit_en_i = 1'b0;
        inj_single_i = 1'b1; tick(); inj_single_i = 1'b0;
        run(3, 1'b0);
        run(4, 1'b1);
        cur_req = "R10";
        run(30, 1'b1);

        // R11: merged requests, restart discards
        cur_req = "R11";
        err_seen = 0;
        bit_en_i = 1'b0;
        inj_single_i = 1'b1; tick(); tick(); inj_single_i = 1'b0;
        inj_pin_i = 1'b1; tick(); inj_pin_i = 1'b0;
        run(2, 1'b0);
        run(5, 1'b1);
        check("merged requests give one error", 1'(err_seen == 1), 1'b1);
        err_seen = 0;
        bit_en_i = 1'b0;
        inj_single_i = 1'b1; tick(); inj_single_i = 1'b0;
        inj_single_i = 1'b1;
        restart(1'b1, 8, 0, 32'hC3);
        inj_single_i = 1'b0;
        run(16, 1'b1);
        check("restart discards request", 1'(err_seen == 0), 1'b1);

        // R7: pin edges
        cur_req = "R7";
        restart(1'b0, 10, 7, 32'h155);
        err_seen = 0;
        run(3, 1'b1);
        inj_pin_i = 1'b1;
        run(12, 1'b1);
        inj_pin_i = 1'b0;
        run(4, 1'b1);
        inj_pin_i = 1'b1;
        run(3, 1'b0);
        run(3, 1'b1);
        inj_pin_i = 1'b0;
        check("pin gives two errors", 1'(err_seen == 2), 1'b1);

        // R8: decade rates
        cur_req = "R8";
        inj_rate_i = 3'd1;
        inj_rate_en_i = 1'b1;
        err_seen = 0;
        run(55, 1'b1);
        check("rate 10 error count", 1'(err_seen == 5), 1'b1);
        inj_rate_en_i = 1'b0;
        run(3, 1'b1);
        inj_rate_i = 3'd0;
        inj_rate_en_i = 1'b1;
        for (int i = 0; i < 60; i++) begin
            bit_en_i = 1'($urandom_range(0, 3) != 0);
            tick();
        end
        bit_en_i = 1'b1;
        inj_rate_i = 3'd2;
        restart(1'b1, 16, 0, 32'hBEEF);
        err_seen = 0;
        run(250, 1'b1);
        check("rate 100 error count", 1'(err_seen == 2), 1'b1);
        inj_rate_i = 3'd3;
        restart(1'b0, 23, 18, 32'h7);
        err_seen = 0;
        run(2005, 1'b1);
        check("rate 1000 error count", 1'(err_seen == 2), 1'b1);

        // R9: rate change at reload only
        cur_req = "R9";
        inj_rate_i = 3'd2;
        restart(1'b0, 7, 6, 32'h1);
        run(40, 1'b1);
        inj_rate_i = 3'd1;
        err_seen = 0;
        run(59, 1'b1);
        check("no early error after rate change", 1'(err_seen == 0), 1'b1);
        run(31, 1'b1);
        inj_rate_en_i = 1'b0;
        run(5, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule